// File: doc/BRIEF.md
# Prescaled 64-bit Time Base

This block keeps a free-running 64-bit tick count that advances once every time a 16-bit down-counting prescaler runs out. The prescaler steps down by one on each clock while a run bit is set; when it sits at zero it loads a programmable reload value and the main count steps up by one. With a reload of zero the count therefore advances on every enabled clock, and with a reload of N it advances once every N+1 enabled clocks.

Software reaches the block over a plain 32-bit register port (valid, write, byte address, write data, registered read data). The port has six word registers: prescaler count, prescaler reload, control, count low half, count high half and a shared 32-bit scratch word. A read of either count half returns that half and, in the same cycle, stores the other half of the same sample in the scratch word, so two reads build a coherent 64-bit value even while the count keeps moving. The live count is also driven out as a 64-bit output for neighbouring logic.

Word map (byte address, bits [1:0] ignored): 0x00 prescaler count, 0x04 prescaler reload, 0x08 control (bit 0 = run), 0x0C count low half (read only), 0x10 count high half (read only), 0x14 scratch. Addresses 0x18 and 0x1C are unmapped.

Top module: `tick_timebase`

## Requirements
- R1: A synchronous active-high reset clears the count, the prescaler count, the reload value, the run bit, the scratch word and the read port, so every register reads back zero after reset.
- R2: While run is set and the prescaler count is non-zero, each clock lowers the prescaler count by one and leaves the 64-bit count unchanged.
- R3: While run is set and the prescaler count is zero, the next clock loads the prescaler with the reload value and adds one to the count; a reload of zero makes the count advance on every enabled clock.
- R4: While run is clear, the prescaler count and the 64-bit count both hold their values.
- R5: The prescaler count (0x00) and reload (0x04) are read/write; only write data bits [15:0] are kept and bits [31:16] read back as zero.
- R6: A read of 0x0C returns count bits [31:0] and loads the scratch word with count bits [63:32] of the same sample.
- R7: A read of 0x10 returns count bits [63:32] and loads the scratch word with count bits [31:0] of the same sample.
- R8: The scratch word (0x14) can be written and read directly with all 32 bits.
- R9: When a half read and a count increment fall in the same cycle, both the returned half and the captured half come from the value before the increment.
- R10: A write to the prescaler count takes effect on that clock instead of the decrement or reload; a count increment due in that cycle still happens.
- R11: Writes to 0x0C, 0x10 and unmapped addresses change nothing, and reads of unmapped addresses return zero.
- R12: Control bit 0 is the run bit; the other control bits are not stored and read back as zero.
- R13: Read data and a one-cycle read-valid strobe appear on the clock after a read request; read-valid stays low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_valid_i | input | 1 | Register access request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 5 | Byte address, bits [1:0] ignored |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data strobe, one cycle after a read |
| count_o | output | 64 | Live 64-bit time base |

## Verification
Two collisions matter: a half read landing on the cycle where the prescaler reaches zero and the count increments, and a software write to the prescaler count landing on a cycle where the running prescaler would otherwise step or reload. Both are provoked by running with small reload values (zero makes every cycle an increment) while reads and writes arrive back to back, with directed cases placed exactly on the increment cycle. A cycle-exact reference model in the bench, built from the requirements, predicts the returned half, the scratch capture through a following scratch read, and the count output on every clock, so a capture taken after the increment or a lost increment is seen at once.

// File: rtl/tick_timebase_pkg.sv
package tick_timebase_pkg;
  // Word indices of the register port (byte address >> 2)
  localparam int unsigned WIDX_PCNT = 0;
  localparam int unsigned WIDX_PRLD = 1;
  localparam int unsigned WIDX_CTRL = 2;
  localparam int unsigned WIDX_CLO  = 3;
  localparam int unsigned WIDX_CHI  = 4;
  localparam int unsigned WIDX_SCR  = 5;
  // Control register: position of the run bit
  localparam int unsigned CTRL_RUN_BIT = 0;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic             ld_en_i,
  input  logic [PRE_W-1:0] ld_val_i,
  input  logic [PRE_W-1:0] reload_i,
  output logic [PRE_W-1:0] cnt_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign tick_o  = run_i && at_zero;
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (ld_en_i) begin
      cnt_q <= ld_val_i;
    end else if (run_i) begin
      cnt_q <= at_zero ? reload_i : cnt_q - PRE_W'(1);
    end
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;

  assign count_o = count_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      count_q <= '0;
    end else if (tick_i) begin
      count_q <= count_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timebase_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int PRE_W  = 16,
  localparam int CNT_W = 2 * DATA_W,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [PRE_W-1:0]  pre_cnt_i,
  output logic              run_o,
  output logic [PRE_W-1:0]  reload_o,
  output logic              pre_ld_o,
  output logic [PRE_W-1:0]  pre_ld_val_o,
  output logic [DATA_W-1:0] scratch_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [IDX_W-1:0]  widx;
  logic              wr, rd;
  logic [DATA_W-1:0] rd_mux;
  logic              run_q;
  logic [PRE_W-1:0]  reload_q;
  logic [DATA_W-1:0] scratch_q;
  logic [1:0]        unused_addr_lsb;

  assign widx            = bus_addr_i[ADDR_W-1:2];
  assign unused_addr_lsb = bus_addr_i[1:0];
  assign wr              = bus_valid_i && bus_write_i;
  assign rd              = bus_valid_i && !bus_write_i;

  assign pre_ld_o     = wr && (widx == IDX_W'(WIDX_PCNT));
  assign pre_ld_val_o = bus_wdata_i[PRE_W-1:0];
  assign run_o        = run_q;
  assign reload_o     = reload_q;
  assign scratch_o    = scratch_q;

  always_comb begin
    rd_mux = '0;
    case (widx)
      IDX_W'(WIDX_PCNT): rd_mux = DATA_W'(pre_cnt_i);
      IDX_W'(WIDX_PRLD): rd_mux = DATA_W'(reload_q);
      IDX_W'(WIDX_CTRL): rd_mux[CTRL_RUN_BIT] = run_q;
      IDX_W'(WIDX_CLO):  rd_mux = count_i[DATA_W-1:0];
      IDX_W'(WIDX_CHI):  rd_mux = count_i[CNT_W-1:DATA_W];
      IDX_W'(WIDX_SCR):  rd_mux = scratch_q;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q     <= 1'b0;
      reload_q  <= '0;
      scratch_q <= '0;
      rdata_o   <= '0;
      rvalid_o  <= 1'b0;
    end else begin
      rvalid_o <= rd;
      rdata_o  <= rd ? rd_mux : '0;
      if (wr && widx == IDX_W'(WIDX_CTRL)) run_q <= bus_wdata_i[CTRL_RUN_BIT];
      if (wr && widx == IDX_W'(WIDX_PRLD)) reload_q <= bus_wdata_i[PRE_W-1:0];
      if (wr && widx == IDX_W'(WIDX_SCR)) begin
        scratch_q <= bus_wdata_i;
      end else if (rd && widx == IDX_W'(WIDX_CLO)) begin
        scratch_q <= count_i[CNT_W-1:DATA_W];
      end else if (rd && widx == IDX_W'(WIDX_CHI)) begin
        scratch_q <= count_i[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int PRE_W  = 16,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  output logic [CNT_W-1:0]  count_o
);
  logic              run_q;
  logic [PRE_W-1:0]  reload_q;
  logic [PRE_W-1:0]  presc_q;
  logic              pre_ld;
  logic [PRE_W-1:0]  pre_ld_val;
  logic              tick;
  logic [DATA_W-1:0] scratch_q;

  tick_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W)) u_regs (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .bus_valid_i (bus_valid_i),
    .bus_write_i (bus_write_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .count_i     (count_o),
    .pre_cnt_i   (presc_q),
    .run_o       (run_q),
    .reload_o    (reload_q),
    .pre_ld_o    (pre_ld),
    .pre_ld_val_o(pre_ld_val),
    .scratch_o   (scratch_q),
    .rdata_o     (bus_rdata_o),
    .rvalid_o    (bus_rvalid_o)
  );

  tick_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .run_i   (run_q),
    .ld_en_i (pre_ld),
    .ld_val_i(pre_ld_val),
    .reload_i(reload_q),
    .cnt_o   (presc_q),
    .tick_o  (tick)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_i (tick),
    .count_o(count_o)
  );
endmodule

// File: rtl/tick_timebase_chk.sv
module tick_timebase_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int PRE_W  = 16,
  localparam int CNT_W = 2 * DATA_W
) (
  input logic              clk_i,
  input logic              rst_i,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              run_q,
  input logic [PRE_W-1:0]  presc_q,
  input logic [PRE_W-1:0]  reload_q,
  input logic [DATA_W-1:0] scratch_q,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              bus_rvalid_o
);
  logic rd_lo, rd_hi, wr_pre;
  assign rd_lo  = bus_valid_i && !bus_write_i && (bus_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(3));
  assign rd_hi  = bus_valid_i && !bus_write_i && (bus_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(4));
  assign wr_pre = bus_valid_i && bus_write_i && (bus_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(0));

  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    rst_i |=> (count_o == '0 && presc_q == '0 && !run_q && !bus_rvalid_o));
  // R2
  hold_while_counting_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && presc_q != '0) |=> $stable(count_o));
  // R3
  step_on_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && presc_q == '0) |=> (count_o == $past(count_o) + CNT_W'(1)));
  // R3
  reload_on_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_q && presc_q == '0 && !wr_pre) |=> (presc_q == $past(reload_q)));
  // R4
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run_q && !wr_pre) |=> ($stable(count_o) && $stable(presc_q)));
  // R6
  low_read_capture_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_lo |=> (bus_rdata_o == $past(count_o[DATA_W-1:0])
               && scratch_q == $past(count_o[CNT_W-1:DATA_W])));
  // R7
  high_read_capture_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_hi |=> (bus_rdata_o == $past(count_o[CNT_W-1:DATA_W])
               && scratch_q == $past(count_o[DATA_W-1:0])));
  // R13
  read_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_valid_i && !bus_write_i) |=> bus_rvalid_o);
  // R13
  no_strobe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !(bus_valid_i && !bus_write_i) |=> !bus_rvalid_o);
endmodule

bind tick_timebase tick_timebase_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .bus_valid_i (bus_valid_i),
  .bus_write_i (bus_write_i),
  .bus_addr_i  (bus_addr_i),
  .count_o     (count_o),
  .run_q       (run_q),
  .presc_q     (presc_q),
  .reload_q    (reload_q),
  .scratch_q   (scratch_q),
  .bus_rdata_o (bus_rdata_o),
  .bus_rvalid_o(bus_rvalid_o)
);

// File: tb/tb_tick_timebase.sv
`timescale 1ns/1ps
module tb_tick_timebase;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int PRE_W  = 16;
  localparam int CNT_W  = 64;

  logic              clk = 1'b0;
  logic              rst;
  logic              bus_valid, bus_write;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              bus_rvalid;
  logic [CNT_W-1:0]  count;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  // reference model state
  logic [CNT_W-1:0]  m_cnt;
  logic [PRE_W-1:0]  m_pre, m_rld;
  logic              m_run;
  logic [DATA_W-1:0] m_scr;

  tick_timebase #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W)) dut (
    .clk_i(clk), .rst_i(rst), .bus_valid_i(bus_valid), .bus_write_i(bus_write),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .bus_rvalid_o(bus_rvalid), .count_o(count)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
    case (a[ADDR_W-1:2])
      3'd0: exp_read = DATA_W'(m_pre);
      3'd1: exp_read = DATA_W'(m_rld);
      3'd2: exp_read = DATA_W'(m_run);
      3'd3: exp_read = m_cnt[31:0];
      3'd4: exp_read = m_cnt[63:32];
      3'd5: exp_read = m_scr;
      default: exp_read = '0;
    endcase
  endfunction

  function automatic string read_tag(input logic [ADDR_W-1:0] a, input bit tick);
    case (a[ADDR_W-1:2])
      3'd0, 3'd1: read_tag = "R5";
      3'd2:       read_tag = "R12";
      3'd3:       read_tag = tick ? "R9" : "R6";
      3'd4:       read_tag = tick ? "R9" : "R7";
      3'd5:       read_tag = "R8";
      default:    read_tag = "R11";
    endcase
  endfunction

  // one bus cycle, called at a falling edge; checks at the next falling edge
  task automatic step(input bit v, input bit w, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input string tag = "");
    logic [DATA_W-1:0] rexp;
    logic [CNT_W-1:0]  n_cnt;
    logic [PRE_W-1:0]  n_pre, n_rld;
    logic              n_run;
    logic [DATA_W-1:0] n_scr;
    bit                tick, rd, wr;
    string             ctag, rtag;
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d;
    rd = v && !w; wr = v && w;
    tick = m_run && (m_pre == '0);
    rexp = exp_read(a);
    n_cnt = tick ? m_cnt + 64'd1 : m_cnt;
    n_pre = m_run ? (tick ? m_rld : m_pre - 16'd1) : m_pre;
    n_rld = m_rld; n_run = m_run; n_scr = m_scr;
    if (wr) begin
      case (a[ADDR_W-1:2])
        3'd0: n_pre = d[15:0];
        3'd1: n_rld = d[15:0];
        3'd2: n_run = d[0];
        3'd5: n_scr = d;
        default: ;
      endcase
    end
    if (rd && a[ADDR_W-1:2] == 3'd3) n_scr = m_cnt[63:32];
    if (rd && a[ADDR_W-1:2] == 3'd4) n_scr = m_cnt[31:0];
    ctag = !m_run ? "R4" : (wr && a[ADDR_W-1:2] == 3'd0) ? "R10" : tick ? "R3" : "R2";
    rtag = (tag != "") ? tag : read_tag(a, tick);
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    check("R13 rvalid", 64'(bus_rvalid), 64'(rd));
    if (rd) check(rtag, 64'(bus_rdata), 64'(rexp));
    check(ctag, count, n_cnt);
    m_cnt = n_cnt; m_pre = n_pre; m_rld = n_rld; m_run = n_run; m_scr = n_scr;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    bus_valid = 0; bus_write = 0; bus_addr = '0; bus_wdata = '0;
    m_cnt = '0; m_pre = '0; m_rld = '0; m_run = 0; m_scr = '0;
    void'($urandom(32'd7321));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: every register reads zero after reset
    for (int k = 0; k < 6; k++) step(1, 0, ADDR_W'(k * 4), '0, "R1");
    check("R1 count", count, '0);
    // R5: reload keeps only low 16 bits
    step(1, 1, 5'h04, 32'hABCD_0003);
    step(1, 0, 5'h04, '0, "R5");
    step(1, 1, 5'h00, 32'hFFFF_0002);
    step(1, 0, 5'h00, '0, "R5");
    // R12: only bit 0 of control is stored
    step(1, 1, 5'h08, 32'hFFFF_FFFF);
    step(1, 0, 5'h08, '0, "R12");
    idle(20);                               // R2 / R3 pacing with reload 3
    // R4: stop and hold
    step(1, 1, 5'h08, 32'hFFFF_FFFE);
    step(1, 0, 5'h08, '0, "R12");
    idle(8);
    step(1, 0, 5'h00, '0, "R4");
    // reload 0: advance on every enabled clock (R3), reads collide with increments (R9)
    step(1, 1, 5'h04, 32'h0);
    step(1, 1, 5'h00, 32'h0);
    step(1, 1, 5'h08, 32'h1);
    idle(4);
    step(1, 0, 5'h0C, '0, "R9");
    step(1, 0, 5'h14, '0, "R9");
    step(1, 0, 5'h10, '0, "R9");
    step(1, 0, 5'h14, '0, "R9");
    // R10: prescaler write while running, incl. on the increment cycle
    step(1, 1, 5'h04, 32'h5);
    step(1, 1, 5'h00, 32'h9);
    step(1, 0, 5'h00, '0, "R10");
    idle(12);
    // R6 / R7 without collision, scratch view
    step(1, 1, 5'h08, 32'h0);
    step(1, 0, 5'h0C, '0, "R6");
    step(1, 0, 5'h14, '0, "R6");
    step(1, 0, 5'h10, '0, "R7");
    step(1, 0, 5'h14, '0, "R7");
    // R8: direct scratch access
    step(1, 1, 5'h14, 32'hDEAD_BEEF);
    step(1, 0, 5'h14, '0, "R8");
    // R11: counter halves and unmapped words ignore writes
    step(1, 1, 5'h0C, 32'h1234_5678);
    step(1, 1, 5'h10, 32'h1234_5678);
    step(1, 1, 5'h18, 32'hFFFF_FFFF);
    step(1, 0, 5'h0C, '0, "R11");
    step(1, 0, 5'h10, '0, "R11");
    step(1, 0, 5'h18, '0, "R11");
    step(1, 0, 5'h1C, '0, "R11");
    step(1, 0, 5'h08, '0, "R11");
    // constrained random phase
    step(1, 1, 5'h08, 32'h1);
    for (int i = 0; i < 4000; i++) begin
      int unsigned sel = $urandom_range(0, 9);
      logic [ADDR_W-1:0] ra = ADDR_W'($urandom_range(0, 7) * 4);
      if (sel < 4)      step(1, 0, ra, '0);
      else if (sel < 5) step(1, 1, 5'h04, $urandom & 32'h0001_0003);
      else if (sel < 6) step(1, 1, 5'h00, $urandom & 32'h0001_0007);
      else if (sel < 7) step(1, 1, 5'h08, ($urandom_range(0, 3) != 0) ? 32'h1 : 32'h0);
      else if (sel < 8) step(1, 1, ra, $urandom);
      else              step(0, 0, '0, '0);
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule